// File: doc/BRIEF.md
# Sixteen-Bit ALU with Packed-BCD Digit to ASCII Conversion

This is a purely combinational arithmetic unit for a small microcoded sequencer. Each microword supplies two 16-bit unsigned operands, chosen upstream from registers, immediates or converter outputs. It also supplies a carry-in select and a 3-bit operation code. The unit returns a 16-bit result, a carry-out and a set of branch flags that the sequencer tests to pick its next microword.

Two operations are arithmetic: add with carry and subtract with carry. The carry-in is either constant zero or constant one. Other common operations are built from these two:
- A compare is a subtract with carry-in one. The equal, greater, less and greater-or-equal flags all come from that single subtraction.
- An increment adds zero to B with carry-in one.
- A constant load adds zero to an immediate with carry-in zero.

Four digit operations pick one 4-bit nibble of a packed-BCD word on operand A. Each turns that nibble into the ASCII code of its character, ready to be sent over a serial transmitter.

Top module: `bcd_ascii_alu`

## Requirements
- R1: With op code 3'b000 (add), res equals (A + B + cin_one) modulo 2^16 and carry_out is the carry out of bit 15.
- R2: With op code 3'b001 (subtract), res equals (A - B - (1 - cin_one)) modulo 2^16 and carry_out is 1 exactly when no borrow occurs, that is when A >= B + (1 - cin_one).
- R3: For a subtract with cin_one = 1, flag_lt is 1 exactly when A < B as unsigned values.
- R4: For every op code, flag_ge equals carry_out and flag_gt equals carry_out AND NOT flag_zero. For a subtract with cin_one = 1 this makes flag_gt mean A > B and flag_ge mean A >= B.
- R5: For every op code, flag_zero is 1 exactly when res is 0, and flag_nonzero is always its complement.
- R6: An add with A = 0 and cin_one = 1 returns B + 1 (increment). An add with A = 0 and cin_one = 0 returns B unchanged (constant load).
- R7: Op codes 3'b1dd are digit operations. The nibble is A[4*dd+3:4*dd], so dd = 3 takes A >> 12 and dd = 0 takes A with no shift.
- R8: For a digit operation, res[7:0] is 0x30 plus the nibble when the nibble is 0 to 9, and 0x37 plus the nibble when it is 10 to 15 (characters 'A' to 'F'). res[15:8] is 0, carry_out is 0, and B and cin_one have no effect.
- R9: The reserved op codes 3'b010 and 3'b011 return res = 0 and carry_out = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 16 | Operand A; minuend, or packed-BCD source for digit ops |
| opnd_b | input | 16 | Operand B; addend, subtrahend or immediate |
| op_sel | input | 3 | Operation code: 000 add, 001 subtract, 1dd digit dd, 010/011 reserved |
| cin_one | input | 1 | Carry-in select: 0 gives carry-in zero, 1 gives carry-in one |
| res | output | 16 | Result |
| carry_out | output | 1 | Carry out of bit 15; for subtract, 1 means no borrow |
| flag_zero | output | 1 | Result is zero |
| flag_nonzero | output | 1 | Result is not zero |
| flag_gt | output | 1 | Carry set and result non-zero (A > B after a compare) |
| flag_lt | output | 1 | Carry clear (A < B after a compare) |
| flag_ge | output | 1 | Carry set (A >= B after a compare) |

## Verification
Every result and flag is a combinational function of the present inputs, so each output is due in the same cycle as its stimulus and no register lies in between. The bench changes inputs only on the falling clock edge. It samples one nanosecond later, well before the next rising edge, so every value it reads has settled from the inputs it has just applied. The compare flags are checked against integer relations for pseudo-random operand pairs and for the equal and extreme pairs. The digit operations are checked at every nibble position with every digit value, while B and the carry-in select are changed to show they have no effect.

// File: rtl/alu_pkg.sv
package alu_pkg;
   localparam int OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      OP_ADC  = 3'b000,
      OP_SBC  = 3'b001,
      OP_RSV2 = 3'b010,
      OP_RSV3 = 3'b011,
      OP_DIG0 = 3'b100,
      OP_DIG1 = 3'b101,
      OP_DIG2 = 3'b110,
      OP_DIG3 = 3'b111
   } alu_op_e;

   localparam logic [7:0] ASCII_ZERO     = 8'h30;
   localparam logic [7:0] ASCII_HEX_BASE = 8'h37;

   function automatic logic op_is_digit(input logic [OP_W-1:0] op);
      return op[OP_W-1];
   endfunction
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int DATA_W      = 16,
   parameter int ADDER_STYLE = 0
) (
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] b_in,
   input  logic              invert_b,
   input  logic              carry_in,
   output logic [DATA_W-1:0] sum,
   output logic              carry_out
);
   logic [DATA_W-1:0] b_eff;

   assign b_eff = invert_b ? ~b_in : b_in;

   generate
      if (ADDER_STYLE == 0) begin : g_behav
         logic [DATA_W:0] wide;
         assign wide      = {1'b0, a_in} + {1'b0, b_eff} + {{DATA_W{1'b0}}, carry_in};
         assign sum       = wide[DATA_W-1:0];
         assign carry_out = wide[DATA_W];
      end else begin : g_ripple
         logic [DATA_W:0] chain;
         assign chain[0] = carry_in;
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign sum[i]       = a_in[i] ^ b_eff[i] ^ chain[i];
            assign chain[i+1]   = (a_in[i] & b_eff[i]) | (chain[i] & (a_in[i] ^ b_eff[i]));
         end
         assign carry_out = chain[DATA_W];
      end
   endgenerate
endmodule

// File: rtl/alu_digit_ascii.sv
module alu_digit_ascii #(
   parameter int DATA_W = 16,
   parameter int NIB_W  = 4,
   parameter int DIGITS = 4,
   localparam int SEL_W = $clog2(DIGITS)
) (
   input  logic [DATA_W-1:0] bcd_src,
   input  logic [SEL_W-1:0]  digit_sel,
   output logic [7:0]        ascii
);
   import alu_pkg::*;

   logic [NIB_W-1:0] nib_arr [DIGITS];
   logic [NIB_W-1:0] nib;

   generate
      for (genvar g = 0; g < DIGITS; g++) begin : g_nib
         assign nib_arr[g] = bcd_src[g*NIB_W +: NIB_W];
      end
   endgenerate

   assign nib = nib_arr[digit_sel];

   always_comb begin
      if (nib < NIB_W'(10)) ascii = ASCII_ZERO + 8'(nib);
      else                  ascii = ASCII_HEX_BASE + 8'(nib);
   end
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] res_in,
   input  logic              carry_in,
   output logic              is_zero,
   output logic              is_nonzero,
   output logic              is_gt,
   output logic              is_lt,
   output logic              is_ge
);
   assign is_zero    = (res_in == '0);
   assign is_nonzero = ~is_zero;
   assign is_ge      = carry_in;
   assign is_lt      = ~carry_in;
   assign is_gt      = carry_in & ~is_zero;
endmodule

// File: rtl/bcd_ascii_alu.sv
module bcd_ascii_alu #(
   parameter int DATA_W      = 16,
   parameter int NIB_W       = 4,
   parameter int DIGITS      = 4,
   parameter int ADDER_STYLE = 0
) (
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [2:0]        op_sel,
   input  logic              cin_one,
   output logic [DATA_W-1:0] res,
   output logic              carry_out,
   output logic              flag_zero,
   output logic              flag_nonzero,
   output logic              flag_gt,
   output logic              flag_lt,
   output logic              flag_ge
);
   import alu_pkg::*;

   localparam int SEL_W = $clog2(DIGITS);

   generate
      if (NIB_W != 4) begin : g_bad_nib
         $error("NIB_W must be 4 for BCD digits");
      end
      if (DIGITS != 4) begin : g_bad_digits
         $error("DIGITS must be 4 to match the 2-bit digit index");
      end
      if (DATA_W < NIB_W * DIGITS) begin : g_bad_width
         $error("DATA_W too small for the digit field");
      end
      if (ADDER_STYLE != 0 && ADDER_STYLE != 1) begin : g_bad_style
         $error("ADDER_STYLE must be 0 or 1");
      end
   endgenerate

   alu_op_e          op;
   logic [DATA_W-1:0] sum;
   logic             sum_carry;
   logic [7:0]       ascii;
   logic             do_sub;

   assign op     = alu_op_e'(op_sel);
   assign do_sub = (op == OP_SBC);

   alu_addsub #(.DATA_W(DATA_W), .ADDER_STYLE(ADDER_STYLE)) u_addsub (
      .a_in      (opnd_a),
      .b_in      (opnd_b),
      .invert_b  (do_sub),
      .carry_in  (cin_one),
      .sum       (sum),
      .carry_out (sum_carry)
   );

   alu_digit_ascii #(.DATA_W(DATA_W), .NIB_W(NIB_W), .DIGITS(DIGITS)) u_digit (
      .bcd_src   (opnd_a),
      .digit_sel (op_sel[SEL_W-1:0]),
      .ascii     (ascii)
   );

   always_comb begin
      unique case (op)
         OP_ADC, OP_SBC: begin
            res       = sum;
            carry_out = sum_carry;
         end
         OP_DIG0, OP_DIG1, OP_DIG2, OP_DIG3: begin
            res       = {{(DATA_W-8){1'b0}}, ascii};
            carry_out = 1'b0;
         end
         default: begin
            res       = '0;
            carry_out = 1'b0;
         end
      endcase
   end

   alu_flags #(.DATA_W(DATA_W)) u_flags (
      .res_in     (res),
      .carry_in   (carry_out),
      .is_zero    (flag_zero),
      .is_nonzero (flag_nonzero),
      .is_gt      (flag_gt),
      .is_lt      (flag_lt),
      .is_ge      (flag_ge)
   );
endmodule

// File: rtl/bcd_ascii_alu_chk.sv
module bcd_ascii_alu_chk #(
   parameter int DATA_W = 16
) (
   input logic [DATA_W-1:0] opnd_a,
   input logic [DATA_W-1:0] opnd_b,
   input logic [2:0]        op_sel,
   input logic              cin_one,
   input logic [DATA_W-1:0] res,
   input logic              carry_out,
   input logic              flag_zero,
   input logic              flag_nonzero,
   input logic              flag_gt,
   input logic              flag_lt,
   input logic              flag_ge
);
   logic [DATA_W:0] add_ref;
   logic [DATA_W:0] sub_ref;
   logic [3:0]      nib;

   always_comb begin
      add_ref = {1'b0, opnd_a} + {1'b0, opnd_b} + {{DATA_W{1'b0}}, cin_one};
      sub_ref = {1'b0, opnd_a} - {1'b0, opnd_b} - {{DATA_W{1'b0}}, ~cin_one};
      nib     = opnd_a[op_sel[1:0]*4 +: 4];
      if (op_sel == 3'b000) begin
         AST_ADD_SUM: assert ({carry_out, res} == add_ref); // R1
      end
      if (op_sel == 3'b001) begin
         AST_SUB_DIFF: assert (res == sub_ref[DATA_W-1:0] && carry_out == ~sub_ref[DATA_W]); // R2
      end
      if (op_sel == 3'b001 && cin_one) begin
         AST_CMP_LT: assert (flag_lt == (opnd_a < opnd_b)); // R3
         AST_CMP_GT: assert (flag_gt == (opnd_a > opnd_b)); // R4
      end
      AST_GE_NOT_LT: assert (flag_ge != flag_lt); // R4
      AST_ZERO_EXCL: assert (flag_zero != flag_nonzero && flag_zero == (res == '0)); // R5
      if (op_sel[2]) begin
         AST_DIGIT_ASCII: assert (res == ((nib < 4'd10) ? DATA_W'(8'h30 + 8'(nib))
                                                        : DATA_W'(8'h37 + 8'(nib))) && !carry_out); // R8
      end
      if (op_sel == 3'b010 || op_sel == 3'b011) begin
         AST_RESERVED_ZERO: assert (res == '0 && !carry_out); // R9
      end
   end
endmodule

bind bcd_ascii_alu bcd_ascii_alu_chk #(.DATA_W(DATA_W)) u_chk (
   .opnd_a       (opnd_a),
   .opnd_b       (opnd_b),
   .op_sel       (op_sel),
   .cin_one      (cin_one),
   .res          (res),
   .carry_out    (carry_out),
   .flag_zero    (flag_zero),
   .flag_nonzero (flag_nonzero),
   .flag_gt      (flag_gt),
   .flag_lt      (flag_lt),
   .flag_ge      (flag_ge)
);

// File: tb/bcd_ascii_alu_bench.sv
`timescale 1ns/1ps
module bcd_ascii_alu_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] opnd_a = '0;
   logic [15:0] opnd_b = '0;
   logic [2:0]  op_sel = '0;
   logic        cin_one = 1'b0;
   logic [15:0] res;
   logic        carry_out, flag_zero, flag_nonzero, flag_gt, flag_lt, flag_ge;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   bcd_ascii_alu u_bcd_ascii_alu (
      .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel), .cin_one(cin_one),
      .res(res), .carry_out(carry_out), .flag_zero(flag_zero),
      .flag_nonzero(flag_nonzero), .flag_gt(flag_gt), .flag_lt(flag_lt),
      .flag_ge(flag_ge)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // Drive on the falling edge, sample 1 ns later: outputs are combinational.
   task automatic apply(input logic [15:0] a, input logic [15:0] b,
                        input logic [2:0] op, input logic ci);
      @(negedge clk);
      opnd_a = a; opnd_b = b; op_sel = op; cin_one = ci;
      #1;
   endtask

   task automatic chk_flags(input string tag, input bit exp_c, input logic [15:0] exp_r);
      chk(flag_zero == (exp_r == 0), {tag, " R5 zero"}, flag_zero, exp_r == 0);
      chk(flag_nonzero == (exp_r != 0), {tag, " R5 nonzero"}, flag_nonzero, exp_r != 0);
      chk(flag_ge == exp_c, {tag, " R4 ge"}, flag_ge, exp_c);
      chk(flag_gt == (exp_c && exp_r != 0), {tag, " R4 gt"}, flag_gt, exp_c && exp_r != 0);
      chk(flag_lt == !exp_c, {tag, " R3 lt"}, flag_lt, !exp_c);
   endtask

   task automatic t_reset_state;
      apply(16'h0, 16'h0, 3'b000, 1'b0);
      chk(res == 16'h0 && carry_out == 1'b0, "R1 idle add 0+0", res, 0);
      chk_flags("idle", 1'b0, 16'h0);
   endtask

   task automatic t_add;
      logic [15:0] av [5] = '{16'h0001, 16'hFFFF, 16'h8000, 16'h1234, 16'hFFFF};
      logic [15:0] bv [5] = '{16'h0002, 16'h0001, 16'h8000, 16'h4321, 16'hFFFF};
      for (int i = 0; i < 5; i++) begin
         for (int c = 0; c < 2; c++) begin
            int unsigned s;
            s = av[i] + bv[i] + c;
            apply(av[i], bv[i], 3'b000, c[0]);
            chk(res == s[15:0], "R1 add result", res, s[15:0]);
            chk(carry_out == s[16], "R1 add carry", carry_out, s[16]);
            chk_flags("R1 add", s[16], s[15:0]);
         end
      end
   endtask

   task automatic t_sub;
      logic [15:0] av [4] = '{16'h0005, 16'h0003, 16'h0000, 16'hFFFF};
      logic [15:0] bv [4] = '{16'h0003, 16'h0003, 16'h0001, 16'h0000};
      for (int i = 0; i < 4; i++) begin
         for (int c = 0; c < 2; c++) begin
            int d;
            bit nb;
            d  = int'(av[i]) - int'(bv[i]) - (1 - c);
            nb = (int'(av[i]) >= int'(bv[i]) + (1 - c));
            apply(av[i], bv[i], 3'b001, c[0]);
            chk(res == d[15:0], "R2 sub result", res, d[15:0]);
            chk(carry_out == nb, "R2 sub no-borrow", carry_out, nb);
         end
      end
   endtask

   task automatic t_compare;
      for (int i = 0; i < 400; i++) begin
         logic [15:0] a, b;
         a = 16'($urandom);
         b = (i % 7 == 0) ? a : 16'($urandom);
         if (i % 11 == 0) b = a + 16'd1;
         apply(a, b, 3'b001, 1'b1);
         chk(flag_lt == (a < b), "R3 compare lt", flag_lt, a < b);
         chk(flag_gt == (a > b), "R4 compare gt", flag_gt, a > b);
         chk(flag_ge == (a >= b), "R4 compare ge", flag_ge, a >= b);
         chk(flag_zero == (a == b), "R5 compare eq", flag_zero, a == b);
      end
      apply(16'h0000, 16'hFFFF, 3'b001, 1'b1);
      chk(flag_lt && !flag_gt, "R3 compare 0 vs max", flag_lt, 1);
      apply(16'hFFFF, 16'h0000, 3'b001, 1'b1);
      chk(flag_gt && !flag_lt, "R4 compare max vs 0", flag_gt, 1);
   endtask

   task automatic t_inc_load;
      apply(16'h0000, 16'h00FE, 3'b000, 1'b1);
      chk(res == 16'h00FF, "R6 increment", res, 16'h00FF);
      apply(16'h0000, 16'hFFFF, 3'b000, 1'b1);
      chk(res == 16'h0000 && carry_out && flag_zero, "R6 increment wrap", res, 0);
      apply(16'h0000, 16'h002A, 3'b000, 1'b0);
      chk(res == 16'h002A && !carry_out, "R6 constant load", res, 16'h002A);
      apply(16'h0000, 16'h0000, 3'b000, 1'b0);
      chk(res == 16'h0000 && flag_zero, "R6 load zero", res, 0);
   endtask

   task automatic t_digits;
      for (int pos = 0; pos < 4; pos++) begin
         for (int v = 0; v < 16; v++) begin
            logic [15:0] a;
            logic [7:0]  e;
            a = 16'h5A5A;
            a[pos*4 +: 4] = v[3:0];
            e = (v < 10) ? 8'(8'h30 + v) : 8'(8'h37 + v);
            apply(a, 16'(v * 977), {1'b1, pos[1:0]}, v[0]);
            chk(res == {8'h00, e}, "R7 R8 digit ascii", res, {8'h00, e});
            chk(!carry_out && !flag_zero, "R8 digit carry/zero", carry_out, 0);
         end
      end
      apply(16'h1234, 16'h0000, 3'b111, 1'b0);
      chk(res == 16'h0031, "R7 digit 3 shift 12", res, 16'h0031);
      apply(16'h1234, 16'hFFFF, 3'b111, 1'b1);
      chk(res == 16'h0031, "R8 B and carry ignored", res, 16'h0031);
      apply(16'h1234, 16'h0000, 3'b100, 1'b0);
      chk(res == 16'h0034, "R7 digit 0 no shift", res, 16'h0034);
   endtask

   task automatic t_reserved;
      apply(16'hFFFF, 16'hFFFF, 3'b010, 1'b1);
      chk(res == 16'h0 && !carry_out, "R9 reserved 010", res, 0);
      chk_flags("R9 reserved 010", 1'b0, 16'h0);
      apply(16'h1234, 16'h4321, 3'b011, 1'b0);
      chk(res == 16'h0 && !carry_out, "R9 reserved 011", res, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_add();
      t_sub();
      t_compare();
      t_inc_load();
      t_digits();
      t_reserved();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule